// File: doc/BRIEF.md
# Occupancy-Sampling Resize Controller

This controller decides when a partitioned queue should be given one more partition or have one taken away. It does not watch the queue every cycle. Instead it reads the occupancy at regular sampling points, adds those readings up over a longer evaluation window, and at the close of each window it asks for one partition fewer when the averaged demand fits in fewer partitions than are switched on.

Growth follows a separate, faster path. Each cycle in which dispatch stalls on a full queue is counted. As soon as that count goes past a threshold, the controller asks for one extra partition at once, without waiting for the window to close. The queue reports how many partitions are active and whether a partition is still being drained. While a drain is pending, both requests are held off. The queue storage and the power gating belong to the surrounding logic.

Top module: `resize_ctrl`

## Requirements
- R1: `shrink_o` is a one-cycle pulse. It can rise only in the cycle that follows the last cycle of an evaluation window. A window is PERIOD_CYC cycles long, and the first window starts with the first clock edge after reset is released.
- R2: Occupancy is read only in the last cycle of each SAMPLE_CYC-cycle sampling interval, so a window holds PERIOD_CYC/SAMPLE_CYC readings. Values of `occ_i` in any other cycle have no effect.
- R3: At the close of a window, the sum of the readings is shifted right by log2(PERIOD_CYC/SAMPLE_CYC) to give the average. The needed partition count is that average divided by PART_SIZE, rounded up. One shrink pulse is issued when the needed count is below `active_i` and `active_i` is greater than 1.
- R4: A stall counter adds one for each cycle with `block_i` high. In the cycle after a stalled cycle that takes the count above OVF_LIMIT, `grow_o` pulses for one cycle.
- R5: A grow request clears the stall counter. A further request therefore needs another OVF_LIMIT+1 stalled cycles.
- R6: The stall counter returns to zero at every window boundary. Stalls are not carried from one window into the next.
- R7: While `busy_i` is high, neither `grow_o` nor `shrink_o` pulses in the following cycle.
- R8: No grow request is issued while `active_i` equals NUM_PARTS.
- R9: When a grow and a shrink would fall in the same cycle, only the grow is issued.
- R10: While `rst_ni` is low, both outputs are low and the counters and the sum are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| occ_i | input | OCC_W | Current number of occupied entries |
| block_i | input | 1 | Dispatch stalled this cycle because the queue is full |
| active_i | input | PCNT_W | Number of partitions currently switched on |
| busy_i | input | 1 | A partition drain is pending |
| grow_o | output | 1 | Request one more partition |
| shrink_o | output | 1 | Request one partition fewer |

## Verification
Both outputs are registered, so each result appears one cycle after the edge that decides it. A grow shows in the cycle after the stalled cycle that crosses the threshold, and a shrink shows in the cycle after a window's last cycle. The bench drives inputs on the falling edge and samples on the next falling edge. It counts window cycles from reset release, so cycle 16 of each window is where a shrink is due. It also records the exact cycle of the first grow pulse and compares that cycle with the expected one, in addition to checking the pulse counts.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  function automatic int unsigned wmin1(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsz_timer.sv
module rsz_timer #(
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned NUM_SMP    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_o,
  output logic period_end_o
);
  localparam int unsigned SC_W = rsz_pkg::wmin1(SAMPLE_CYC);
  localparam int unsigned PC_W = rsz_pkg::wmin1(NUM_SMP);

  logic [SC_W-1:0] sc_q;
  logic [PC_W-1:0] pc_q;

  assign sample_o     = (sc_q == SC_W'(SAMPLE_CYC - 1));
  assign period_end_o = sample_o && (pc_q == PC_W'(NUM_SMP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q <= '0;
      pc_q <= '0;
    end else if (sample_o) begin
      sc_q <= '0;
      pc_q <= period_end_o ? '0 : pc_q + 1'b1;
    end else begin
      sc_q <= sc_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsz_sampler.sv
module rsz_sampler #(
  parameter int unsigned OCC_W   = 6,
  parameter int unsigned NUM_SMP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             period_end_i,
  input  logic [OCC_W-1:0] occ_i,
  output logic [OCC_W-1:0] avg_o
);
  localparam int unsigned SH    = $clog2(NUM_SMP);
  localparam int unsigned ACC_W = OCC_W + SH;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum   = acc_q + ACC_W'(occ_i);
  assign avg_o = OCC_W'(sum >> SH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (period_end_i) acc_q <= '0;
    else if (sample_i)     acc_q <= sum;
  end
endmodule

// File: rtl/rsz_overflow.sv
module rsz_overflow #(
  parameter int unsigned OVF_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic period_end_i,
  input  logic grant_i,
  output logic req_o
);
  localparam int unsigned OW = $clog2(OVF_LIMIT + 2);

  logic [OW-1:0] cnt_q;

  // this stall is the one that pushes the count past the limit
  assign req_o = block_i && (cnt_q >= OW'(OVF_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= '0;
    else if (period_end_i || grant_i)               cnt_q <= '0;
    else if (block_i && cnt_q <= OW'(OVF_LIMIT))    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/resize_ctrl.sv
module resize_ctrl #(
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned PERIOD_CYC = 16,
  parameter int unsigned OVF_LIMIT  = 4,
  parameter int unsigned PART_SIZE  = 8,
  parameter int unsigned NUM_PARTS  = 4,
  localparam int unsigned OCC_W  = $clog2(PART_SIZE * NUM_PARTS + 1),
  localparam int unsigned PCNT_W = $clog2(NUM_PARTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic              block_i,
  input  logic [PCNT_W-1:0] active_i,
  input  logic              busy_i,
  output logic              grow_o,
  output logic              shrink_o
);
  localparam int unsigned NUM_SMP = PERIOD_CYC / SAMPLE_CYC;
  localparam int unsigned NW      = OCC_W + 1;

  logic             sample, period_end;
  logic [OCC_W-1:0] avg;
  logic [NW-1:0]    need;
  logic             grow_req, grow_fire, shrink_fire;

  rsz_timer #(.SAMPLE_CYC(SAMPLE_CYC), .NUM_SMP(NUM_SMP)) u_timer (
    .clk_i, .rst_ni, .sample_o(sample), .period_end_o(period_end)
  );

  rsz_sampler #(.OCC_W(OCC_W), .NUM_SMP(NUM_SMP)) u_sampler (
    .clk_i, .rst_ni, .sample_i(sample), .period_end_i(period_end),
    .occ_i, .avg_o(avg)
  );

  rsz_overflow #(.OVF_LIMIT(OVF_LIMIT)) u_ovf (
    .clk_i, .rst_ni, .block_i, .period_end_i(period_end),
    .grant_i(grow_fire), .req_o(grow_req)
  );

  assign need = (NW'(avg) + NW'(PART_SIZE - 1)) / NW'(PART_SIZE);

  assign grow_fire = grow_req && !busy_i && (active_i < PCNT_W'(NUM_PARTS));

  assign shrink_fire = period_end && !busy_i && !grow_fire
                    && (active_i > PCNT_W'(1))
                    && (need < NW'(active_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grow_o   <= 1'b0;
      shrink_o <= 1'b0;
    end else begin
      grow_o   <= grow_fire;
      shrink_o <= shrink_fire;
    end
  end
endmodule

// File: rtl/resize_ctrl_chk.sv
module resize_ctrl_chk #(
  parameter int unsigned NUM_PARTS = 4,
  parameter int unsigned PCNT_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              block_i,
  input logic              busy_i,
  input logic [PCNT_W-1:0] active_i,
  input logic              period_end,
  input logic              grow_o,
  input logic              shrink_o
);
  a_r1_shrink_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shrink_o |-> $past(period_end));
  a_r3_keep_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shrink_o |-> $past(active_i) > PCNT_W'(1));
  a_r4_grow_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grow_o |-> $past(block_i));
  a_r7_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !grow_o && !shrink_o);
  a_r8_no_grow_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grow_o |-> $past(active_i) < PCNT_W'(NUM_PARTS));
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grow_o, shrink_o}));
  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shrink_o |=> !shrink_o);
endmodule

bind resize_ctrl resize_ctrl_chk #(.NUM_PARTS(NUM_PARTS), .PCNT_W(PCNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .block_i(block_i), .busy_i(busy_i),
  .active_i(active_i), .period_end(period_end), .grow_o(grow_o), .shrink_o(shrink_o)
);

// File: tb/resize_ctrl_test.sv
`timescale 1ns/1ps
module resize_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] occ = '0;
  logic       blk = 1'b0;
  logic [2:0] act = 3'd4;
  logic       busy = 1'b0;
  logic       grow, shrink;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  resize_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .occ_i(occ), .block_i(blk),
    .active_i(act), .busy_i(busy), .grow_o(grow), .shrink_o(shrink)
  );

  // occ, active, stall count, busy, exp grows, exp shrinks, exp first-grow cycle
  localparam int NV = 11;
  localparam int VEC [NV][7] = '{
    '{ 5, 4,  0, 0, 0, 1, 0},   // R3 shrink, R1
    '{20, 3,  0, 0, 0, 0, 0},   // R3 need 3
    '{17, 3,  0, 0, 0, 0, 0},   // R3 round up
    '{16, 3,  0, 0, 0, 1, 0},   // R3 exact
    '{ 0, 1,  0, 0, 0, 0, 0},   // R3 keep one
    '{30, 2,  5, 0, 1, 0, 5},   // R4 crossing
    '{30, 2,  4, 0, 0, 0, 0},   // R4 at limit
    '{30, 2,  4, 0, 0, 0, 0},   // R6 no carry over
    '{30, 2, 10, 0, 2, 0, 5},   // R5 re-arm
    '{ 0, 4,  6, 1, 0, 0, 0},   // R7 busy
    '{30, 4,  6, 0, 0, 0, 0}    // R8 at max
  };

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // one 16-cycle window; sample cycles are 4,8,12,16
  task automatic run_window(input int occ_smp, input int occ_last, input int occ_oth,
                            input int a, input bit b, input int blo, input int bhi,
                            output int ng, output int ns, output int fg, output int sbad);
    ng = 0; ns = 0; fg = 0; sbad = 0;
    for (int it = 1; it <= 16; it++) begin
      occ  = 6'((it == 16) ? occ_last : ((it % 4 == 0) ? occ_smp : occ_oth));
      act  = 3'(a);
      busy = b;
      blk  = (it >= blo) && (it <= bhi);
      @(posedge clk);
      @(negedge clk);
      if (grow) begin ng++; if (fg == 0) fg = it; end
      if (shrink) begin ns++; if (it != 16) sbad++; end
    end
    blk = 1'b0;
  endtask

  initial begin
    int ng, ns, fg, sb;
    repeat (3) @(negedge clk);
    check(!grow && !shrink, "R10 outputs low in reset", {grow, shrink}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_window(VEC[v][0], VEC[v][0], VEC[v][0], VEC[v][1], VEC[v][3] != 0,
                 1, VEC[v][2], ng, ns, fg, sb);
      check(ng == VEC[v][4], $sformatf("R4/R5/R7/R8 grow count vec%0d", v), ng, VEC[v][4]);
      check(ns == VEC[v][5], $sformatf("R3/R7 shrink count vec%0d", v), ns, VEC[v][5]);
      check(fg == VEC[v][6], $sformatf("R4 first grow cycle vec%0d", v), fg, VEC[v][6]);
      check(sb == 0, $sformatf("R1 shrink off window end vec%0d", v), sb, 0);
    end

    // R2: high occupancy only between sampling points
    run_window(0, 0, 32, 2, 0, 1, 0, ng, ns, fg, sb);
    check(ns == 1, "R2 off-sample occupancy ignored", ns, 1);

    // R3: average of 32,32,32,0 is 24 -> need 3
    run_window(32, 0, 0, 3, 0, 1, 0, ng, ns, fg, sb);
    check(ns == 0, "R3 uses average not last sample", ns, 0);

    // R9: crossing lands on the window's last cycle
    run_window(0, 0, 0, 3, 0, 12, 16, ng, ns, fg, sb);
    check(ng == 1 && fg == 16, "R9 grow issued at end", fg, 16);
    check(ns == 0, "R9 shrink dropped", ns, 0);

    // R10: reset clears stall count
    for (int it = 1; it <= 3; it++) begin
      blk = 1'b1; act = 3'd2; @(posedge clk); @(negedge clk);
    end
    blk = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!grow && !shrink, "R10 outputs low in mid-run reset", {grow, shrink}, 0);
    rst_n = 1'b1;
    run_window(30, 30, 30, 2, 0, 1, 2, ng, ns, fg, sb);
    check(ng == 0, "R10 stall count cleared", ng, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule